// File: doc/BRIEF.md
# Glitch-Free Output Clock Divider with Gated Enable

This block takes either a fast oscillator clock or a slower reference clock, chosen by a bypass select, and divides it by a ratio picked from a 3-bit code. The divided clock is fanned out to six true/complement output pairs. Every ratio gives equal high and low times. At divide-by-one the selected source passes straight through the gate, so its duty cycle is kept.

An output enable that may arrive at any time is captured on a rising source edge. It is applied on the falling source edge that follows. It is only applied while the divided clock is low, so a pulse is never cut short or started halfway. A newly written ratio code is taken up only where a divided period ends, so no period is shortened.

An active-high master reset clears the divider and holds every true output low and every complement output high.

Top module: `fsd_out_divider`

## Requirements
- R1: With the code's top bit at 0, codes 0, 1, 2 and 3 (bits [1:0]) divide the source by 2, 4, 8 and 16.
- R2: With the code's top bit at 1, codes 4, 5, 6 and 7 divide the source by 1, 2, 4 and 8.
- R3: For every ratio R of 2 or more, the output is high for R/2 source periods and then low for R/2 source periods. Each period begins at a rising source edge.
- R4: At ratio 1, the enabled true output follows the source level: high while the source is high and low while it is low.
- R5: A code change is taken up at the first rising source edge at which a full divided period has ended. Until then the ratio in force stays unchanged.
- R6: The enable is sampled on a rising source edge and takes effect on the next falling source edge. It takes effect only if the divided clock is low at that falling edge, which is always true at ratio 1. Otherwise it waits for a later falling edge.
- R7: While disabled, every true output is 0 and every complement output is 1.
- R8: While master reset is high, every true output is 0 and every complement output is 1. The divider and the enable are cleared, and the ratio in force returns to 1. After release, the first rising source edge starts a new period with the code present at that edge.
- R9: With bypass at 0 the oscillator clock is the source. With bypass at 1 the reference clock is the source. Edges on the clock that is not selected have no effect.
- R10: All six pairs carry the same value, and each complement output is always the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast oscillator clock, the source when bypass is 0 |
| ref_clk | input | 1 | Reference clock, the source when bypass is 1 |
| bypass | input | 1 | Source select: 1 picks ref_clk, 0 picks vco_clk |
| n_code | input | 3 | Ratio code, taken up at a period boundary |
| oe | input | 1 | Output enable, asynchronous, active high |
| mr | input | 1 | Master reset, asynchronous, active high |
| out_p | output | 6 | True clock outputs |
| out_n | output | 6 | Complement clock outputs |

## Verification
On every source cycle the assertions check the following. The enable changes only while the divided clock is low or the ratio is 1. The divided level and the ratio in force change only at terminal count and load points. A disabled gate gives low true outputs, complements stay inverted, and outputs are parked on leaving reset. Some behaviour can only be shown by the bench's scenarios, which run a reference model through them: the actual ratios of the eight codes, the half-period lengths, the exact latency of the enable, and the boundary at which a code written mid-period is taken up. The same holds for switching the source between the two clocks.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  localparam int CODE_W        = 3;
  localparam int RATIO_LOG_MAX = 4;                 // largest ratio is 2**4
  localparam int CNT_W         = RATIO_LOG_MAX - 1; // counts half periods

  typedef logic [CODE_W-1:0] ncode_t;

  localparam ncode_t CODE_AT_RESET = 3'b100;        // ratio 1

  // Top bit picks the family: 0 -> 2,4,8,16 ; 1 -> 1,2,4,8
  function automatic int unsigned ratio_of(input ncode_t c);
    int unsigned base;
    base = c[CODE_W-1] ? 32'd1 : 32'd2;
    return base << c[1:0];
  endfunction

  function automatic logic [CNT_W-1:0] half_minus_one(input ncode_t c);
    int unsigned h;
    h = ratio_of(c) >> 1;
    return (h == 0) ? '0 : CNT_W'(h - 1);
  endfunction
endpackage

// File: rtl/fsd_src_mux.sv
module fsd_src_mux (
  input  logic vco_clk,
  input  logic ref_clk,
  input  logic bypass,
  output logic src_clk
);
  assign src_clk = bypass ? ref_clk : vco_clk;
endmodule

// File: rtl/fsd_div_core.sv
module fsd_div_core
  import fsd_pkg::*;
(
  input  logic   src_clk,
  input  logic   mr,
  input  ncode_t n_code,
  output logic   ddiv,
  output logic   div1_mode,
  output logic   term_evt,
  output logic   load_evt,
  output ncode_t cur_code
);
  logic [CNT_W-1:0] cnt;

  assign div1_mode = (ratio_of(cur_code) == 32'd1);
  assign term_evt  = div1_mode | (cnt == half_minus_one(cur_code));
  assign load_evt  = term_evt & ~ddiv;  // end of low half = end of period

  always_ff @(posedge src_clk or posedge mr) begin
    if (mr) begin
      cnt      <= '0;
      ddiv     <= 1'b0;
      cur_code <= CODE_AT_RESET;
    end else if (load_evt) begin
      cur_code <= n_code;
      cnt      <= '0;
      ddiv     <= (ratio_of(n_code) != 32'd1);
    end else if (term_evt) begin
      cnt      <= '0;
      ddiv     <= ~ddiv;
    end else begin
      cnt      <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fsd_oe_gate.sv
module fsd_oe_gate (
  input  logic src_clk,
  input  logic mr,
  input  logic oe,
  input  logic ddiv,
  input  logic div1_mode,
  output logic en_g,
  output logic gated
);
  logic oe_s1;
  logic pre;

  always_ff @(posedge src_clk or posedge mr) begin
    if (mr) oe_s1 <= 1'b0;
    else    oe_s1 <= oe;
  end

  // Applied on the falling edge, and only when the divided level is low
  always_ff @(negedge src_clk or posedge mr) begin
    if (mr)                      en_g <= 1'b0;
    else if (div1_mode || !ddiv) en_g <= oe_s1;
  end

  assign pre   = div1_mode ? src_clk : ddiv;
  assign gated = pre & en_g & ~mr;
endmodule

// File: rtl/fsd_out_divider.sv
module fsd_out_divider
  import fsd_pkg::*;
#(
  parameter int NUM_PAIRS = 6
)(
  input  logic                 vco_clk,
  input  logic                 ref_clk,
  input  logic                 bypass,
  input  logic [CODE_W-1:0]    n_code,
  input  logic                 oe,
  input  logic                 mr,
  output logic [NUM_PAIRS-1:0] out_p,
  output logic [NUM_PAIRS-1:0] out_n
);
  logic   src_clk;
  logic   ddiv;
  logic   div1_mode;
  logic   term_evt;
  logic   load_evt;
  ncode_t cur_code;
  logic   en_g;
  logic   gated;

  fsd_src_mux u_mux (
    .vco_clk (vco_clk),
    .ref_clk (ref_clk),
    .bypass  (bypass),
    .src_clk (src_clk)
  );

  fsd_div_core u_core (
    .src_clk   (src_clk),
    .mr        (mr),
    .n_code    (n_code),
    .ddiv      (ddiv),
    .div1_mode (div1_mode),
    .term_evt  (term_evt),
    .load_evt  (load_evt),
    .cur_code  (cur_code)
  );

  fsd_oe_gate u_gate (
    .src_clk   (src_clk),
    .mr        (mr),
    .oe        (oe),
    .ddiv      (ddiv),
    .div1_mode (div1_mode),
    .en_g      (en_g),
    .gated     (gated)
  );

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    assign out_p[i] = gated;
    assign out_n[i] = ~gated;
  end
endmodule

// File: rtl/fsd_out_divider_chk.sv
module fsd_out_divider_chk #(
  parameter int NUM_PAIRS = 6
)(
  input logic                 src_clk,
  input logic                 mr,
  input logic [NUM_PAIRS-1:0] out_p,
  input logic [NUM_PAIRS-1:0] out_n,
  input logic                 en_g,
  input logic                 ddiv,
  input logic                 div1_mode,
  input logic                 term_evt,
  input logic                 load_evt,
  input logic [2:0]           cur_code
);
  AST_PARK_AFTER_RESET: assert property (@(posedge src_clk) disable iff (mr) $past(mr) |-> (out_p == '0)); // R8
  AST_PAIR_INVERSE: assert property (@(negedge src_clk) disable iff (mr) out_n == ~out_p); // R10
  AST_DISABLED_LOW: assert property (@(posedge src_clk) disable iff (mr) !en_g |-> (out_p == '0)); // R7
  AST_CODE_AT_BOUNDARY: assert property (@(posedge src_clk) disable iff (mr) !load_evt |=> $stable(cur_code)); // R5
  AST_TOGGLE_AT_TC: assert property (@(posedge src_clk) disable iff (mr) !term_evt |=> $stable(ddiv)); // R3
  AST_ENABLE_CLEAN: assert property (@(posedge src_clk) disable iff (mr) !$stable(en_g) |-> (div1_mode || !ddiv)); // R6
endmodule

bind fsd_out_divider fsd_out_divider_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .src_clk   (src_clk),
  .mr        (mr),
  .out_p     (out_p),
  .out_n     (out_n),
  .en_g      (en_g),
  .ddiv      (ddiv),
  .div1_mode (div1_mode),
  .term_evt  (term_evt),
  .load_evt  (load_evt),
  .cur_code  (cur_code)
);

// File: tb/fsd_out_divider_bench.sv
`timescale 1ns/1ps
module fsd_out_divider_bench;
  localparam int NP = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          run_vco = 1'b1;
  logic          bypass  = 1'b0;
  logic [2:0]    n_code  = 3'd0;
  logic          oe      = 1'b0;
  logic          mr      = 1'b1;
  logic          vco_clk, ref_clk;
  logic [NP-1:0] out_p, out_n;

  assign vco_clk = run_vco & clk;
  assign ref_clk = ~run_vco & clk;

  fsd_out_divider #(.NUM_PAIRS(NP)) u_fsd_out_divider (
    .vco_clk (vco_clk),
    .ref_clk (ref_clk),
    .bypass  (bypass),
    .n_code  (n_code),
    .oe      (oe),
    .mr      (mr),
    .out_p   (out_p),
    .out_n   (out_n)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R8";
  bit    done     = 1'b0;

  // Reference model: period length, position in period, enable pipeline
  int m_len, m_pos, m_left;
  bit m_oe1, m_en;

  function automatic int code_ratio(input logic [2:0] c);
    case (c)
      3'd0: return 2;   3'd1: return 4;   3'd2: return 8;  3'd3: return 16;
      3'd4: return 1;   3'd5: return 2;   3'd6: return 4;  default: return 8;
    endcase
  endfunction

  function automatic bit src_running();
    return bypass ? !run_vco : run_vco;
  endfunction

  task automatic model_clear();
    m_len = 1; m_pos = 0; m_left = 0; m_oe1 = 0; m_en = 0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  task automatic compare(input bit high_half);
    bit pre, e;
    logic [NP-1:0] ev;
    if (m_len == 1) pre = high_half && src_running();
    else            pre = (m_pos < m_len / 2);
    e  = pre && m_en && !mr;
    ev = {NP{e}};
    check(out_p == ev, cur_req, "true outputs", out_p, ev);
    check(out_n == ~ev, "R10", "complement outputs", out_n, ~ev);
  endtask

  initial model_clear();

  always begin
    @(posedge clk); #5;
    if (mr) model_clear();
    else if (src_running()) begin
      m_oe1 = oe;
      if (m_left == 0) begin
        m_len = code_ratio(n_code); m_pos = 0; m_left = m_len - 1;
      end else begin
        m_pos++; m_left--;
      end
    end
    if (!done) compare(1'b1);
  end

  always begin
    @(negedge clk); #5;
    if (mr) model_clear();
    else if (src_running()) begin
      if (m_len == 1 || m_pos >= m_len / 2) m_en = m_oe1;
    end
    if (!done) compare(1'b0);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    check(out_p == '0 && out_n == '1, "R8", "parked in reset", out_p, '0);

    // R1: first family
    mr = 1'b0; oe = 1'b1; n_code = 3'd0; cur_req = "R1"; tick(20);
    n_code = 3'd1; tick(40);
    n_code = 3'd2; cur_req = "R3"; tick(50);
    n_code = 3'd3; cur_req = "R1"; tick(70);

    // R5: codes written mid-period
    cur_req = "R5";
    n_code = 3'd1; tick(9);
    n_code = 3'd2; tick(3);
    n_code = 3'd3; tick(3);
    n_code = 3'd1; tick(30);

    // R4 / R2: second family
    n_code = 3'd4; cur_req = "R4"; tick(12);
    cur_req = "R2";
    n_code = 3'd5; tick(30);
    n_code = 3'd6; tick(30);
    n_code = 3'd7; tick(40);

    // R6: enable changes at various phases
    cur_req = "R6";
    n_code = 3'd2; tick(21);
    oe = 1'b0; tick(1); tick(12);
    oe = 1'b1; tick(5);
    oe = 1'b0; tick(3);
    oe = 1'b1; tick(20);
    n_code = 3'd4; tick(6);
    oe = 1'b0; tick(4);
    oe = 1'b1; tick(4);

    // R7: disabled state
    cur_req = "R7";
    n_code = 3'd1; oe = 1'b0; tick(12);
    check(out_p == '0 && out_n == '1, "R7", "disabled outputs", out_p, '0);
    oe = 1'b1; tick(10);

    // R8: reset during run
    cur_req = "R8";
    tick(7);
    mr = 1'b1; tick(1);
    check(out_p == '0 && out_n == '1, "R8", "reset mid-run", out_p, '0);
    tick(2);
    mr = 1'b0; tick(20);

    // R9: source selection
    cur_req = "R9";
    mr = 1'b1; tick(1);
    run_vco = 1'b0; bypass = 1'b0; n_code = 3'd0;
    mr = 1'b0; oe = 1'b1; tick(10);
    check(out_p == '0, "R9", "unselected clock ignored", out_p, '0);
    bypass = 1'b1; tick(24);
    run_vco = 1'b1; tick(1);
    check(out_n == ~out_p, "R10", "pair inverse", out_n, ~out_p);
    bypass = 1'b0; n_code = 3'd5; tick(24);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule